// File: doc/BRIEF.md
# Strided 3D Tensor Transfer Engine

This block copies a three-dimensional slice of a larger tensor between external memory and on-chip SRAM. A command gives a base address for each memory, three extents (planes, rows, words per row) and two strides (plane step and row step on the external side), along with a direction bit. The engine walks the slice word by word. It reads one word from the source memory, waits for the data to return, and then writes that word to the destination memory. On the external side the walk is strided and may skip addresses. On the SRAM side the words are packed one after another.

The command port and both memory request ports are valid/ready. A transfer is taken when `cmd_valid` and `cmd_ready` are both high on a clock edge. A memory request is taken when its `*_req_valid` and `*_req_ready` are both high. While `*_req_ready` is low, the engine keeps the request valid and holds its address and data unchanged. Read responses come back on `*_rsp_valid` with no back-pressure, and at most one read is outstanding at a time. A command with the clear flag set does not start a transfer. It only empties the walk counters and the done state. `done` is a plain status pulse.

Top module: `tensor_xfer_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0 and neither memory request valid is asserted.
- R2: With `cmd_dir`=0 (load), the engine reads external word `ext_base + z*z_stride + y*y_stride + x` for each z < z_ext, y < y_ext and x < x_ext. The word order has x innermost, then y, then z. Word number k of that order is written to SRAM address `sram_base + k`.
- R3: With `cmd_dir`=1 (store), the engine reads SRAM words `sram_base + k` in order. It writes word k to the external address given by the same strided formula as R2.
- R4: Each transfer moves exactly `z_ext*y_ext*x_ext` words, with one read and one write per word. External requests use `ext_req_we`, and SRAM requests use `sram_req_we`, where 1 means write.
- R5: `done` is high for exactly one cycle: the cycle right after the edge on which the final write is accepted.
- R6: `cmd_ready` is high only while the engine is idle. A command presented during a transfer is not taken and does not change the transfer in progress.
- R7: A command with any extent equal to zero issues no memory request. It raises `done` in the cycle after the command is accepted.
- R8: A command with `cmd_clear`=1 issues no memory request and produces no `done` pulse. The engine stays ready for the next command.
- R9: While a request's ready is low, its valid stays high and its address and write data stay stable. A write is issued only after the read data for that word has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_clear | input | 1 | Clear counters and done state; no transfer |
| cmd_dir | input | 1 | 0 = external to SRAM, 1 = SRAM to external |
| cmd_ext_base | input | AW | External base address |
| cmd_sram_base | input | AW | SRAM base address |
| cmd_z_ext | input | EW | Plane count |
| cmd_y_ext | input | EW | Rows per plane |
| cmd_x_ext | input | EW | Words per row |
| cmd_z_stride | input | AW | External address step between planes |
| cmd_y_stride | input | AW | External address step between rows |
| ext_req_valid | output | 1 | External request valid |
| ext_req_ready | input | 1 | External request accepted |
| ext_req_we | output | 1 | External request is a write |
| ext_req_addr | output | AW | External word address |
| ext_req_wdata | output | DW | External write data |
| ext_rsp_valid | input | 1 | External read data valid |
| ext_rsp_data | input | DW | External read data |
| sram_req_valid | output | 1 | SRAM request valid |
| sram_req_ready | input | 1 | SRAM request accepted |
| sram_req_we | output | 1 | SRAM request is a write |
| sram_req_addr | output | AW | SRAM word address |
| sram_req_wdata | output | DW | SRAM write data |
| sram_rsp_valid | input | 1 | SRAM read data valid |
| sram_rsp_data | input | DW | SRAM read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs loads and stores whose row and plane strides are larger than the row length. An engine that mixes up the loop order, or adds a stride in the wrong place, leaves scrambled or misplaced words in the destination memory, and the bench compares every word against an image it builds itself. It runs a transfer with a zero extent and a clear command. A design that still walks the slice there would either emit memory traffic or give a spurious or missing `done`. It runs transfers under toggling ready signals, where an engine that drops or changes a stalled request would lose or duplicate words. It also offers a second command in the middle of a transfer, which a design that accepts commands while busy would let corrupt the copy.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2,
    ST_WR   = 2'd3
  } tx_state_e;

  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } tx_dir_e;
endpackage

// File: rtl/tx_walker.sv
module tx_walker #(
  parameter int AW = 16,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] ext_base,
  input  logic [AW-1:0] sram_base,
  input  logic [EW-1:0] z_ext,
  input  logic [EW-1:0] y_ext,
  input  logic [EW-1:0] x_ext,
  input  logic [AW-1:0] z_stride,
  input  logic [AW-1:0] y_stride,
  output logic [AW-1:0] ext_addr,
  output logic [AW-1:0] sram_addr,
  output logic          last
);
  logic [EW-1:0] x_q, y_q, z_q;
  logic [EW-1:0] xl_q, yl_q, zl_q;
  logic [AW-1:0] zs_q, ys_q, sb_q;
  logic [AW-1:0] row_q, plane_q, lin_q;
  logic          x_end, y_end, z_end;

  assign x_end = (x_q == xl_q);
  assign y_end = (y_q == yl_q);
  assign z_end = (z_q == zl_q);
  assign last  = x_end && y_end && z_end;

  assign ext_addr  = row_q + AW'(x_q);
  assign sram_addr = sb_q + lin_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      x_q <= '0; y_q <= '0; z_q <= '0;
      xl_q <= '0; yl_q <= '0; zl_q <= '0;
      zs_q <= '0; ys_q <= '0; sb_q <= '0;
      row_q <= '0; plane_q <= '0; lin_q <= '0;
    end else if (load) begin
      x_q <= '0; y_q <= '0; z_q <= '0;
      xl_q <= x_ext - 1'b1;
      yl_q <= y_ext - 1'b1;
      zl_q <= z_ext - 1'b1;
      zs_q <= z_stride;
      ys_q <= y_stride;
      sb_q <= sram_base;
      row_q <= ext_base;
      plane_q <= ext_base;
      lin_q <= '0;
    end else if (step) begin
      lin_q <= lin_q + 1'b1;
      if (!x_end) begin
        x_q <= x_q + 1'b1;
      end else begin
        x_q <= '0;
        if (!y_end) begin
          y_q   <= y_q + 1'b1;
          row_q <= row_q + ys_q;
        end else begin
          y_q     <= '0;
          z_q     <= z_q + 1'b1;
          plane_q <= plane_q + zs_q;
          row_q   <= plane_q + zs_q;
        end
      end
    end
  end

  AST_SRAM_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clear) |=> (sram_addr == $past(sram_addr) + 1'b1)); // R2

  AST_X_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clear && !x_end) |=> (ext_addr == $past(ext_addr) + 1'b1)); // R3
endmodule

// File: rtl/tx_mover.sv
module tx_mover #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_clear,
  input  logic          cmd_dir,
  input  logic          cmd_zero,
  input  logic          last,
  output logic          walk_load,
  output logic          walk_clear,
  output logic          walk_step,
  output logic          dir_store,
  output logic          rd_valid,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  import tx_pkg::*;

  tx_state_e     st_q;
  logic          dir_q;
  logic [DW-1:0] data_q;
  logic          cmd_fire, wr_fire;

  assign cmd_ready  = (st_q == ST_IDLE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign rd_valid   = (st_q == ST_RD);
  assign wr_valid   = (st_q == ST_WR);
  assign wr_data    = data_q;
  assign wr_fire    = wr_valid && wr_ready;
  assign dir_store  = dir_q;
  assign walk_clear = cmd_fire && cmd_clear;
  assign walk_load  = cmd_fire && !cmd_clear && !cmd_zero;
  assign walk_step  = wr_fire && !last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= DIR_LOAD;
      data_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_fire && !cmd_clear) begin
            if (cmd_zero) begin
              done <= 1'b1;
            end else begin
              dir_q <= cmd_dir;
              st_q  <= ST_RD;
            end
          end
        end
        ST_RD:   if (rd_ready) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid) begin
            data_q <= rsp_data;
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_ready) begin
            if (last) begin
              st_q <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st_q <= ST_RD;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid); // R9

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !(rd_valid || wr_valid)); // R6
endmodule

// File: rtl/tensor_xfer_engine.sv
module tensor_xfer_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_clear,
  input  logic          cmd_dir,
  input  logic [AW-1:0] cmd_ext_base,
  input  logic [AW-1:0] cmd_sram_base,
  input  logic [EW-1:0] cmd_z_ext,
  input  logic [EW-1:0] cmd_y_ext,
  input  logic [EW-1:0] cmd_x_ext,
  input  logic [AW-1:0] cmd_z_stride,
  input  logic [AW-1:0] cmd_y_stride,
  output logic          ext_req_valid,
  input  logic          ext_req_ready,
  output logic          ext_req_we,
  output logic [AW-1:0] ext_req_addr,
  output logic [DW-1:0] ext_req_wdata,
  input  logic          ext_rsp_valid,
  input  logic [DW-1:0] ext_rsp_data,
  output logic          sram_req_valid,
  input  logic          sram_req_ready,
  output logic          sram_req_we,
  output logic [AW-1:0] sram_req_addr,
  output logic [DW-1:0] sram_req_wdata,
  input  logic          sram_rsp_valid,
  input  logic [DW-1:0] sram_rsp_data,
  output logic          done
);
  logic          walk_load, walk_clear, walk_step, last, dir_store;
  logic          rd_valid, rd_ready, rsp_valid, wr_valid, wr_ready;
  logic [DW-1:0] rsp_data, wr_data;
  logic [AW-1:0] ext_addr, sram_addr;
  logic          cmd_zero;

  assign cmd_zero = (cmd_z_ext == '0) || (cmd_y_ext == '0) || (cmd_x_ext == '0);

  tx_walker #(.AW(AW), .EW(EW)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .load(walk_load), .clear(walk_clear), .step(walk_step),
    .ext_base(cmd_ext_base), .sram_base(cmd_sram_base),
    .z_ext(cmd_z_ext), .y_ext(cmd_y_ext), .x_ext(cmd_x_ext),
    .z_stride(cmd_z_stride), .y_stride(cmd_y_stride),
    .ext_addr(ext_addr), .sram_addr(sram_addr), .last(last)
  );

  tx_mover #(.DW(DW)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_clear(cmd_clear), .cmd_dir(cmd_dir), .cmd_zero(cmd_zero),
    .last(last),
    .walk_load(walk_load), .walk_clear(walk_clear), .walk_step(walk_step),
    .dir_store(dir_store),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .done(done)
  );

  // Role steering: the source memory takes reads, the destination takes writes
  assign ext_req_valid  = dir_store ? wr_valid : rd_valid;
  assign ext_req_we     = dir_store;
  assign ext_req_addr   = ext_addr;
  assign ext_req_wdata  = wr_data;
  assign sram_req_valid = dir_store ? rd_valid : wr_valid;
  assign sram_req_we    = !dir_store;
  assign sram_req_addr  = sram_addr;
  assign sram_req_wdata = wr_data;
  assign rd_ready  = dir_store ? sram_req_ready : ext_req_ready;
  assign wr_ready  = dir_store ? ext_req_ready  : sram_req_ready;
  assign rsp_valid = dir_store ? sram_rsp_valid : ext_rsp_valid;
  assign rsp_data  = dir_store ? sram_rsp_data  : ext_rsp_data;

  AST_EXT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_valid && !ext_req_ready) |=> (ext_req_valid && $stable(ext_req_addr))); // R9

  AST_SRAM_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req_valid && !sram_req_ready) |=> (sram_req_valid && $stable(sram_req_addr))); // R9

  AST_NO_TRAFFIC_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_clear || cmd_zero)) |=> !(ext_req_valid || sram_req_valid)); // R7
endmodule

// File: tb/tensor_xfer_engine_bench.sv
module tensor_xfer_engine_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int EW = 8;
  localparam int EXT_WORDS  = 512;
  localparam int SRAM_WORDS = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_clear = 1'b0, cmd_dir = 1'b0;
  logic [AW-1:0] cmd_ext_base = '0, cmd_sram_base = '0, cmd_z_stride = '0, cmd_y_stride = '0;
  logic [EW-1:0] cmd_z_ext = '0, cmd_y_ext = '0, cmd_x_ext = '0;
  logic          cmd_ready, done;
  logic          ext_req_valid, ext_req_we, sram_req_valid, sram_req_we;
  logic [AW-1:0] ext_req_addr, sram_req_addr;
  logic [DW-1:0] ext_req_wdata, sram_req_wdata;
  logic          ext_rsp_valid = 1'b0, sram_rsp_valid = 1'b0;
  logic [DW-1:0] ext_rsp_data = '0, sram_rsp_data = '0;
  logic          ext_req_ready, sram_req_ready;

  tensor_xfer_engine #(.AW(AW), .DW(DW), .EW(EW)) u_tensor_xfer_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_clear(cmd_clear), .cmd_dir(cmd_dir),
    .cmd_ext_base(cmd_ext_base), .cmd_sram_base(cmd_sram_base),
    .cmd_z_ext(cmd_z_ext), .cmd_y_ext(cmd_y_ext), .cmd_x_ext(cmd_x_ext),
    .cmd_z_stride(cmd_z_stride), .cmd_y_stride(cmd_y_stride),
    .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready), .ext_req_we(ext_req_we),
    .ext_req_addr(ext_req_addr), .ext_req_wdata(ext_req_wdata),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data),
    .sram_req_valid(sram_req_valid), .sram_req_ready(sram_req_ready), .sram_req_we(sram_req_we),
    .sram_req_addr(sram_req_addr), .sram_req_wdata(sram_req_wdata),
    .sram_rsp_valid(sram_rsp_valid), .sram_rsp_data(sram_rsp_data),
    .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wr_count = 0;
  int req_count = 0;
  int last_wr_cyc = -1;
  int hold_viol = 0;
  logic stall_mode = 1'b0;

  logic [DW-1:0] ext_mem  [EXT_WORDS];
  logic [DW-1:0] sram_mem [SRAM_WORDS];
  logic [DW-1:0] ext_exp  [EXT_WORDS];
  logic [DW-1:0] sram_exp [SRAM_WORDS];

  assign ext_req_ready  = !(stall_mode && (cyc % 3 == 0));
  assign sram_req_ready = !(stall_mode && (cyc % 2 == 1));

  logic          ext_stall_q = 1'b0, sram_stall_q = 1'b0;
  logic [AW-1:0] ext_addr_q = '0, sram_addr_q = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ext_rsp_valid  <= 1'b0;
    sram_rsp_valid <= 1'b0;
    if (ext_stall_q && (!ext_req_valid || ext_req_addr != ext_addr_q)) hold_viol <= hold_viol + 1;
    if (sram_stall_q && (!sram_req_valid || sram_req_addr != sram_addr_q)) hold_viol <= hold_viol + 1;
    ext_stall_q  <= ext_req_valid && !ext_req_ready;
    sram_stall_q <= sram_req_valid && !sram_req_ready;
    ext_addr_q   <= ext_req_addr;
    sram_addr_q  <= sram_req_addr;
    if (ext_req_valid && ext_req_ready) begin
      req_count <= req_count + 1;
      if (ext_req_we) begin
        ext_mem[int'(ext_req_addr) % EXT_WORDS] <= ext_req_wdata;
        wr_count <= wr_count + 1;
        last_wr_cyc <= cyc;
      end else begin
        ext_rsp_valid <= 1'b1;
        ext_rsp_data  <= ext_mem[int'(ext_req_addr) % EXT_WORDS];
      end
    end
    if (sram_req_valid && sram_req_ready) begin
      req_count <= req_count + 1;
      if (sram_req_we) begin
        sram_mem[int'(sram_req_addr) % SRAM_WORDS] <= sram_req_wdata;
        wr_count <= wr_count + 1;
        last_wr_cyc <= cyc;
      end else begin
        sram_rsp_valid <= 1'b1;
        sram_rsp_data  <= sram_mem[int'(sram_req_addr) % SRAM_WORDS];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill_mems(input int seed);
    for (int i = 0; i < EXT_WORDS; i++) begin
      ext_mem[i] = DW'(i * 7 + seed);
      ext_exp[i] = ext_mem[i];
    end
    for (int i = 0; i < SRAM_WORDS; i++) begin
      sram_mem[i] = DW'(i * 13 + seed + 1000);
      sram_exp[i] = sram_mem[i];
    end
  endtask

  task automatic issue(input bit clr, input bit dir, input int eb, input int sb,
                       input int zn, input int yn, input int xn, input int zs, input int ys);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_clear = clr; cmd_dir = dir;
    cmd_ext_base = AW'(eb); cmd_sram_base = AW'(sb);
    cmd_z_ext = EW'(zn); cmd_y_ext = EW'(yn); cmd_x_ext = EW'(xn);
    cmd_z_stride = AW'(zs); cmd_y_stride = AW'(ys);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_clear = 1'b0;
  endtask

  // Waits for done; returns number of cycles done was high and the cycle gap to the last write
  task automatic wait_done(output int highs, output int gap);
    int waited = 0;
    highs = 0; gap = -99;
    while (!done && waited < 2000) begin
      @(negedge clk); waited++;
    end
    if (done) begin
      gap = cyc - last_wr_cyc;
      while (done) begin
        highs++;
        @(negedge clk);
      end
    end
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    for (int i = 0; i < EXT_WORDS; i++) if (ext_mem[i] !== ext_exp[i]) bad++;
    for (int i = 0; i < SRAM_WORDS; i++) if (sram_mem[i] !== sram_exp[i]) bad++;
    check(bad == 0, req, "mismatched memory words", bad, 0);
  endtask

  task automatic run_copy(input bit dir, input int eb, input int sb, input int zn, input int yn,
                          input int xn, input int zs, input int ys, input string req);
    int highs, gap, k, w0;
    k = 0;
    for (int z = 0; z < zn; z++)
      for (int y = 0; y < yn; y++)
        for (int x = 0; x < xn; x++) begin
          int ea = (eb + z * zs + y * ys + x) % EXT_WORDS;
          int sa = (sb + k) % SRAM_WORDS;
          if (dir) ext_exp[ea] = sram_mem[sa];
          else     sram_exp[sa] = ext_mem[ea];
          k++;
        end
    w0 = wr_count;
    issue(1'b0, dir, eb, sb, zn, yn, xn, zs, ys);
    wait_done(highs, gap);
    compare_all(req);
    check(wr_count - w0 == k, "R4", "words written", wr_count - w0, k);
    check(highs == 1, "R5", "done high cycles", highs, 1);
    check(gap == 1, "R5", "done delay after final write", gap, 1);
  endtask

  task automatic t_reset;
    check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(!ext_req_valid && !sram_req_valid, "R1", "request valid after reset",
          int'(ext_req_valid) + int'(sram_req_valid), 0);
  endtask

  task automatic t_load;
    fill_mems(3);
    run_copy(1'b0, 10, 5, 2, 3, 4, 40, 8, "R2");
  endtask

  task automatic t_store;
    fill_mems(11);
    run_copy(1'b1, 100, 20, 3, 2, 3, 50, 9, "R3");
  endtask

  task automatic t_stall;
    int h0;
    fill_mems(21);
    stall_mode = 1'b1;
    h0 = hold_viol;
    run_copy(1'b0, 7, 40, 2, 2, 5, 60, 16, "R9");
    run_copy(1'b1, 300, 60, 2, 3, 2, 33, 11, "R9");
    stall_mode = 1'b0;
    check(hold_viol == h0, "R9", "stalled request changed", hold_viol - h0, 0);
  endtask

  task automatic t_zero;
    int r0, highs;
    fill_mems(31);
    r0 = req_count;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dir = 1'b0; cmd_clear = 1'b0;
    cmd_z_ext = EW'(2); cmd_y_ext = EW'(0); cmd_x_ext = EW'(4);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done == 1'b1, "R7", "done after zero-extent command", int'(done), 1);
    highs = 0;
    for (int i = 0; i < 8; i++) begin
      if (done) highs++;
      @(negedge clk);
    end
    check(highs == 1, "R7", "done cycles for zero extent", highs, 1);
    check(req_count == r0, "R7", "requests for zero extent", req_count - r0, 0);
    compare_all("R7");
  endtask

  task automatic t_clear;
    int r0, highs;
    fill_mems(41);
    r0 = req_count;
    issue(1'b1, 1'b0, 10, 5, 2, 2, 2, 20, 4);
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      if (done) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R8", "done after clear", highs, 0);
    check(req_count == r0, "R8", "requests after clear", req_count - r0, 0);
    check(cmd_ready == 1'b1, "R8", "ready after clear", int'(cmd_ready), 1);
    compare_all("R8");
    run_copy(1'b0, 0, 0, 1, 2, 3, 10, 5, "R8");
  endtask

  task automatic t_busy;
    int highs, gap, k;
    fill_mems(51);
    k = 0;
    for (int z = 0; z < 2; z++)
      for (int y = 0; y < 2; y++)
        for (int x = 0; x < 3; x++) begin
          sram_exp[(70 + k) % SRAM_WORDS] = ext_mem[(200 + z * 30 + y * 10 + x) % EXT_WORDS];
          k++;
        end
    issue(1'b0, 1'b0, 200, 70, 2, 2, 3, 30, 10);
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b0, "R6", "ready during transfer", int'(cmd_ready), 0);
    cmd_valid = 1'b1; cmd_dir = 1'b1; cmd_ext_base = AW'(0); cmd_sram_base = AW'(0);
    cmd_z_ext = EW'(1); cmd_y_ext = EW'(1); cmd_x_ext = EW'(4);
    repeat (4) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(highs, gap);
    check(highs == 1, "R6", "done for first command only", highs, 1);
    repeat (4) @(negedge clk);
    check(!ext_req_valid && !sram_req_valid, "R6", "traffic from rejected command",
          int'(ext_req_valid) + int'(sram_req_valid), 0);
    compare_all("R6");
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        fill_mems(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_store();
        t_stall();
        t_zero();
        t_clear();
        t_busy();
      end
      begin
        while (wd < 150000) begin
          @(posedge clk); wd++;
        end
        check(1'b0, "WATCHDOG", "run did not finish", wd, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule